// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block is a register-mapped controller for a small array of one-time-programmable fuse words. Software reaches it over a plain register bus: an access strobe, a write flag, a byte address and a 32-bit write value. Reads return their data on `bus_rdata` one cycle after the request. A set of control, status and power registers sits in the low address range. Above them is a word window with one 32-bit location for each fuse block.

A program write to the window only burns fuses when three conditions hold together: the unlock key matches a fixed code, program power is switched on, and the program-enable bit is set. Burning can only turn bits from 0 to 1, so a write ORs its data into the stored word. Further options refine this:
- Lock mode freezes a block for good.
- Mirror mode keeps a second copy of each block and merges the two on reads.
- Auto-check reads the block back after a program and flags any requested bit that did not stick.

Every refused or failed operation leaves a sticky error flag, which software clears with a mask write. The array model includes one deliberately defective location, set by parameters, so that auto-check and mirror recovery can be shown.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control (0x20), error (0x24), key (0x2C) and power (0x54) registers read zero, and every fuse word, mirror copy and lock is clear.
- R2: Reads return the value held at the rising edge that samples the request. The data appears on `bus_rdata` after that edge and holds until the next read. The stored widths are: control bits [4:0] (bit0 read power, bit1 auto-check, bit2 mirror, bit3 margin read, bit4 lock mode), key bits [15:0], power bits [2:0] (bit0 switch one, bit1 switch two, bit2 program enable).
- R3: A write to fuse block N at byte address 0x1000+4*N programs only when key equals 0x8810, power bit0 is 1 and power bit2 is 1. Otherwise the array is unchanged and error bit0 is set.
- R4: Programming ORs the write data into the stored word, so no fuse bit ever returns to 0.
- R5: A program made while control bit4 is set also locks the block. Any later program to a locked block leaves its data unchanged and sets error bit1.
- R6: With control bit2 set, a program also ORs its data into the block's mirror copy. A read with control bit2 set returns the OR of both copies, and a read with it clear returns the primary copy only.
- R7: With control bit1 set, the block is read back in the cycle after a program. If any requested 1 is missing from the readback (the OR of both copies when mirroring was on at the time of the write), error bit2 is set. Block DEFECT_BLK (default 5) cannot hold bits DEFECT_BITS (default 0x100) in its primary copy.
- R8: A window read while control bit0 is clear returns 0 and sets error bit2's neighbour, error bit3.
- R9: A write to 0x28 clears the error bits selected by ones in its low 14 bits and leaves the other error bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
On every cycle, the embedded properties check three things. Fuse words and locks only ever gain bits. A locked block and its mirror stay frozen. An unauthorised window write leaves the array untouched and raises the authorisation flag, and an unpowered window read returns zero with its flag.

Only the bench scenarios can show the rest: the merged mirror read that restores the defective bit, the delayed auto-check flag, and partial mask clearing. The bench also sweeps every power-switch setting against matching and non-matching keys, with the expected array contents computed in the bench.

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
  parameter int          NBLK        = 24,
  parameter int          AW          = 13,
  parameter logic [15:0] KEY         = 16'h8810,
  parameter int          DEFECT_BLK  = 5,
  parameter logic [31:0] DEFECT_BITS = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata
);
  localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int XW = AW - 3;

  localparam logic [AW-1:0] A_CTRL = AW'(12'h020);
  localparam logic [AW-1:0] A_ERR  = AW'(12'h024);
  localparam logic [AW-1:0] A_ECLR = AW'(12'h028);
  localparam logic [AW-1:0] A_KEY  = AW'(12'h02C);
  localparam logic [AW-1:0] A_PWR  = AW'(12'h054);

  logic [4:0]             ctrl_q;
  logic [3:0]             err_q;
  logic [15:0]            key_q;
  logic [2:0]             pwr_q;
  logic [NBLK-1:0][31:0]  fuse_q, mirr_q;
  logic [NBLK-1:0]        lock_q;
  logic                   chk_pend_q, chk_dbl_q;
  logic [IW-1:0]          chk_blk_q;
  logic [31:0]            chk_data_q;

  wire [XW-1:0] widx   = bus_addr[AW-2:2];
  wire          in_win = bus_addr[AW-1] && (widx < XW'(NBLK));
  wire [IW-1:0] blk    = widx[IW-1:0];
  wire          wr_acc = bus_en && bus_we;
  wire          rd_acc = bus_en && !bus_we;
  wire          wr_win = wr_acc && in_win;
  wire          rd_win = rd_acc && in_win;

  wire          auth    = (key_q == KEY) && pwr_q[0] && pwr_q[2];
  wire          blk_lk  = lock_q[blk];
  wire          prog    = wr_win && auth && !blk_lk;
  wire [31:0]   bad     = (blk == IW'(DEFECT_BLK)) ? DEFECT_BITS : 32'h0;

  wire [31:0]   rb       = fuse_q[chk_blk_q] | (chk_dbl_q ? mirr_q[chk_blk_q] : 32'h0);
  wire          chk_fail = chk_pend_q && |(chk_data_q & ~rb);

  wire [3:0] err_set = {rd_win && !ctrl_q[0], chk_fail,
                        wr_win && auth && blk_lk, wr_win && !auth};
  wire [3:0] err_clr = (wr_acc && bus_addr == A_ECLR) ? bus_wdata[3:0] : 4'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      err_q      <= '0;
      key_q      <= '0;
      pwr_q      <= '0;
      fuse_q     <= '0;
      mirr_q     <= '0;
      lock_q     <= '0;
      chk_pend_q <= 1'b0;
      chk_dbl_q  <= 1'b0;
      chk_blk_q  <= '0;
      chk_data_q <= '0;
    end else begin
      err_q <= (err_q & ~err_clr) | err_set;
      if (wr_acc && bus_addr == A_CTRL) ctrl_q <= bus_wdata[4:0];
      if (wr_acc && bus_addr == A_KEY)  key_q  <= bus_wdata[15:0];
      if (wr_acc && bus_addr == A_PWR)  pwr_q  <= bus_wdata[2:0];
      if (prog) begin
        fuse_q[blk] <= fuse_q[blk] | (bus_wdata & ~bad);
        if (ctrl_q[2]) mirr_q[blk] <= mirr_q[blk] | bus_wdata;
        if (ctrl_q[4]) lock_q[blk] <= 1'b1;
      end
      chk_pend_q <= prog && ctrl_q[1];
      if (prog) begin
        chk_blk_q  <= blk;
        chk_data_q <= bus_wdata;
        chk_dbl_q  <= ctrl_q[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_acc) begin
      if (in_win)
        bus_rdata <= ctrl_q[0] ? (fuse_q[blk] | (ctrl_q[2] ? mirr_q[blk] : 32'h0)) : 32'h0;
      else begin
        case (bus_addr)
          A_CTRL:  bus_rdata <= {27'h0, ctrl_q};
          A_ERR:   bus_rdata <= {28'h0, err_q};
          A_KEY:   bus_rdata <= {16'h0, key_q};
          A_PWR:   bus_rdata <= {29'h0, pwr_q};
          default: bus_rdata <= 32'h0;
        endcase
      end
    end
  end

  AST_FUSE_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fuse_q & $past(fuse_q)) == $past(fuse_q))); // R4
  AST_LOCK_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q))); // R5
  AST_UNAUTH_NO_BURN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && !auth) |=> (fuse_q == $past(fuse_q) && mirr_q == $past(mirr_q) && err_q[0])); // R3
  AST_NOPWR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_win && !ctrl_q[0]) |=> (bus_rdata == 32'h0 && err_q[3])); // R8

  for (genvar g = 0; g < NBLK; g++) begin : g_lockchk
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[g] |=> (fuse_q[g] == $past(fuse_q[g]) && mirr_q[g] == $past(mirr_q[g]))); // R5
  end
endmodule

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  localparam int          NBLK = 24;
  localparam int          AW   = 13;
  localparam int          DBLK = 5;
  localparam logic [31:0] DBIT = 32'h0000_0100;
  localparam logic [12:0] A_CTRL = 13'h020, A_ERR = 13'h024, A_ECLR = 13'h028,
                          A_KEY = 13'h02C, A_PWR = 13'h054;

  logic clk = 0, rst_n = 0, bus_en = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int total = 0, fails = 0;

  logic [4:0]  m_ctrl = 0;
  logic [3:0]  m_err = 0;
  logic [15:0] m_key = 0;
  logic [2:0]  m_pwr = 0;
  logic [31:0] m_fuse [NBLK];
  logic [31:0] m_mirr [NBLK];
  logic        m_lock [NBLK];

  otp_fuse_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #4 clk = ~clk;

  function automatic logic [12:0] fa(input int n);
    return 13'h1000 + 13'(4 * n);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic set_ctrl(input logic [4:0] v); m_ctrl = v; wr(A_CTRL, 32'(v)); endtask
  task automatic set_key(input logic [15:0] v); m_key = v; wr(A_KEY, 32'(v)); endtask
  task automatic set_pwr(input logic [2:0] v);  m_pwr = v; wr(A_PWR, 32'(v)); endtask

  task automatic prog(input int b, input logic [31:0] d);
    logic [31:0] eff;
    if (!(m_key == 16'h8810 && m_pwr[0] && m_pwr[2])) m_err[0] = 1;
    else if (m_lock[b]) m_err[1] = 1;
    else begin
      m_fuse[b] |= d & ~((b == DBLK) ? DBIT : 32'h0);
      if (m_ctrl[2]) m_mirr[b] |= d;
      if (m_ctrl[4]) m_lock[b] = 1;
      eff = m_fuse[b] | (m_ctrl[2] ? m_mirr[b] : 32'h0);
      if (m_ctrl[1] && (d & ~eff) != 0) m_err[2] = 1;
    end
    wr(fa(b), d);
  endtask

  task automatic chk_err(input string req);
    logic [31:0] r;
    rd(A_ERR, r); check(req, r, 32'(m_err));
  endtask

  task automatic clr_err(input logic [31:0] mask);
    m_err &= ~mask[3:0]; wr(A_ECLR, mask);
  endtask

  task automatic chk_blk(input string req, input int b);
    logic [31:0] r, e;
    if (m_ctrl[0]) e = m_fuse[b] | (m_ctrl[2] ? m_mirr[b] : 32'h0);
    else begin e = 0; m_err[3] = 1; end
    rd(fa(b), r); check(req, r, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] r, hold;
    for (int i = 0; i < NBLK; i++) begin m_fuse[i] = 0; m_mirr[i] = 0; m_lock[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_CTRL, r); check("R1 ctrl", r, 0);
    rd(A_ERR, r);  check("R1 err", r, 0);
    rd(A_KEY, r);  check("R1 key", r, 0);
    rd(A_PWR, r);  check("R1 pwr", r, 0);
    set_ctrl(5'h01);
    for (int i = 0; i < NBLK; i++) chk_blk("R1 fuse", i);
    // R2 widths
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, r); check("R2 ctrl", r, 32'h1F);
    wr(A_KEY, 32'hFFFF_FFFF);  rd(A_KEY, r);  check("R2 key", r, 32'hFFFF);
    wr(A_PWR, 32'hFFFF_FFFF);  rd(A_PWR, r);  check("R2 pwr", r, 32'h7);
    set_ctrl(5'h01); set_pwr(0); set_key(0);
    // R3 sweep power settings against keys
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 3; k++) begin
        set_pwr(3'(p));
        set_key(k == 0 ? 16'h8810 : (k == 1 ? 16'h0000 : 16'h8811));
        prog(1, 32'h1 << (p * 3 + k));
        chk_err("R3 err"); clr_err(32'h3FFF);
        chk_blk("R3 data", 1);
      end
    end
    set_pwr(3'b101); set_key(16'h8810);
    // R4 OR accumulation
    prog(2, 32'h0000_00F0); prog(2, 32'h0000_000F); prog(2, 32'h0);
    chk_blk("R4 or", 2); check("R4 value", m_fuse[2], 32'hFF);
    // R5 locking
    set_ctrl(5'h11); prog(3, 32'hA); set_ctrl(5'h01);
    prog(3, 32'h5); chk_blk("R5 frozen", 3); chk_err("R5 err"); clr_err(32'h3FFF);
    // R6 mirror recovery on the defective block
    set_ctrl(5'h05); prog(DBLK, 32'h0000_0101);
    chk_blk("R6 merged", DBLK); check("R6 merged value", m_fuse[DBLK] | m_mirr[DBLK], 32'h101);
    set_ctrl(5'h01); chk_blk("R6 primary", DBLK);
    // R7 auto-check
    set_ctrl(5'h03); prog(DBLK, 32'h0000_0100); chk_err("R7 mismatch");
    check("R7 flag", 32'(m_err[2]), 1); clr_err(32'h3FFF);
    set_ctrl(5'h07); prog(DBLK, 32'h0000_0100); chk_err("R7 mirror ok");
    set_ctrl(5'h03); prog(4, 32'h0000_0C00); chk_err("R7 good block");
    // R8 unpowered read
    set_ctrl(5'h00); chk_blk("R8 zero", 4); chk_err("R8 err");
    // R9 partial clear
    set_pwr(0); prog(6, 32'h1); chk_err("R9 both");
    clr_err(32'hFFFF_C001); chk_err("R9 partial");
    clr_err(32'h0000_0008); chk_err("R9 rest");
    // R2 read data holds across idle cycles and writes
    set_ctrl(5'h01);
    rd(fa(2), hold);
    repeat (3) @(negedge clk);
    check("R2 hold idle", bus_rdata, hold);
    wr(A_KEY, 32'h1234); check("R2 hold write", bus_rdata, hold);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule